// File: doc/BRIEF.md
# Seven-Channel Tick-Driven PWM Controller

This block generates seven independent pulse-width waveforms from a small register-mapped control space. Six channels drive external output pins and a seventh drives an internal signal only. Every channel draws its time base from one of five source tick inputs. The whole design runs in one clock domain, so each source arrives as a single-cycle enable pulse and not as a separate clock.

A channel's waveform begins with a high phase and then enters a low phase. The high phase lasts one more source tick than the channel's high-count register, and the low phase lasts one more tick than its low-count register, so the period is anywhere from 2 to 131072 ticks. Three gates control a channel, and software sets them in this order: a divider-run gate, a counter-advance gate, then the output gate. Clearing the divider-run gate resets the channel's counter, and only while that gate is clear can the channel's source field be changed. A per-channel bypass option sends the selected tick stream straight to the output. A new count written to a running channel takes effect at the start of the next period.

Top module: `tick_pwm_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, and `pwm_out` and `int_out` are low.
- R2: Every register reads back the last written 32-bit word, except for source fields that were locked (R9). Read data appears on `rdata` one cycle after `addr`. Addresses outside the map read zero. The map is: select at 0x00, output control at 0x04, run gate at 0x08, advance gate at 0x0C, high count of channel n at 0x10+8n, and low count of channel n at 0x14+8n. Addresses must be word aligned.
- R3: With both gates set, a channel's waveform is high for (H+1) source ticks and then low for (L+1) ticks, where H and L are bits [15:0] of its high-count and low-count registers.
- R4: While bit n of the run-gate register is clear, channel n is held at the start of its high phase, and the current count registers are loaded into it.
- R5: While channel n's run-gate bit is set and its advance-gate bit (bit n at 0x0C) is clear, channel n's phase and count stay frozen.
- R6: A channel's output equals its waveform only while both output-control bits are set: bit n (enable) and bit 7+n (transfer mode). Otherwise the output is low. Channels 0 to 5 appear on `pwm_out[n]` and channel 6 appears on `int_out`.
- R7: When select bit 21+n is set, channel n's output is the selected source tick delayed by one cycle, and its count registers have no effect.
- R8: Select bits [3n+2:3n] choose `src_tick[idx]` for idx 0 to 4. An idx of 5 to 7 chooses no source, so the channel never advances.
- R9: A write to the select register leaves channel n's source field unchanged while channel n's run-gate bit is set.
- R10: A write to the count registers of a running channel takes effect at the next low-to-high period boundary, and the phases already in progress keep their old lengths.
- R11: All channels run at the same time, each with its own source and its own counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| src_tick | input | 5 | Source tick enables, one cycle wide |
| pwm_out | output | 6 | External channel outputs 0 to 5 |
| int_out | output | 1 | Internal channel 6 output |

## Verification
A register write is captured at the first clock edge. The output changes two edges after the tick that ends a phase: one edge updates the phase register and the next updates the output register. Bypass adds a one-cycle delay to the tick. Read data is due one cycle after the address is applied. The bench therefore compares run lengths counted at falling edges and does not time individual edges, so these fixed delays cancel out. Where it does check a level after a write, it first waits at least three falling edges.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int NCH    = 7;
  localparam int NSRC   = 5;
  localparam int SEL_W  = 3;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_SEL  = 8'h00;
  localparam logic [ADDR_W-1:0] A_OUT  = 8'h04;
  localparam logic [ADDR_W-1:0] A_RUN  = 8'h08;
  localparam logic [ADDR_W-1:0] A_ADV  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_TBL  = 8'h10;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_t;
endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs
  import pwmc_pkg::*;
#(
  parameter int N  = NCH,
  parameter int SW = SEL_W,
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [N-1:0][SW-1:0]   sel_v,
  output logic [N-1:0]           byp_v,
  output logic [N-1:0]           oe_v,
  output logic [N-1:0]           tm_v,
  output logic [N-1:0]           run_v,
  output logic [N-1:0]           adv_v,
  output logic [N-1:0][CW-1:0]   hi_v,
  output logic [N-1:0][CW-1:0]   lo_v
);
  localparam int BYP_LSB = N * SW;
  localparam int TM_LSB  = N;
  localparam int IDX_W   = $clog2(N);
  localparam logic [AW-1:0] TBL_END = A_TBL + AW'(8 * N);

  logic [DW-1:0] sel_q, out_q, run_q, adv_q;
  logic [DW-1:0] hi_q [N];
  logic [DW-1:0] lo_q [N];

  logic [AW-1:0]    off;
  logic             tbl_hit, tbl_lo;
  logic [IDX_W-1:0] tbl_idx;

  always_comb begin
    off     = addr - A_TBL;
    tbl_hit = (addr >= A_TBL) && (addr < TBL_END) && (addr[1:0] == 2'b00);
    tbl_lo  = off[2];
    tbl_idx = off[IDX_W+2:3];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      out_q <= '0;
      run_q <= '0;
      adv_q <= '0;
      for (int c = 0; c < N; c++) begin
        hi_q[c] <= '0;
        lo_q[c] <= '0;
      end
    end else if (wr_en) begin
      if (addr == A_SEL) begin
        for (int b = BYP_LSB; b < DW; b++) sel_q[b] <= wdata[b];
        for (int c = 0; c < N; c++)
          if (!run_q[c]) sel_q[c*SW +: SW] <= wdata[c*SW +: SW];
      end else if (addr == A_OUT) begin
        out_q <= wdata;
      end else if (addr == A_RUN) begin
        run_q <= wdata;
      end else if (addr == A_ADV) begin
        adv_q <= wdata;
      end else if (tbl_hit) begin
        if (tbl_lo) lo_q[tbl_idx] <= wdata;
        else        hi_q[tbl_idx] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (addr == A_SEL) begin
      rdata <= sel_q;
    end else if (addr == A_OUT) begin
      rdata <= out_q;
    end else if (addr == A_RUN) begin
      rdata <= run_q;
    end else if (addr == A_ADV) begin
      rdata <= adv_q;
    end else if (tbl_hit) begin
      rdata <= tbl_lo ? lo_q[tbl_idx] : hi_q[tbl_idx];
    end else begin
      rdata <= '0;
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_fan
    assign sel_v[c] = sel_q[c*SW +: SW];
    assign byp_v[c] = sel_q[BYP_LSB + c];
    assign oe_v[c]  = out_q[c];
    assign tm_v[c]  = out_q[TM_LSB + c];
    assign run_v[c] = run_q[c];
    assign adv_v[c] = adv_q[c];
    assign hi_v[c]  = hi_q[c][CW-1:0];
    assign lo_v[c]  = lo_q[c][CW-1:0];
  end
endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan
  import pwmc_pkg::*;
#(
  parameter int NS = NSRC,
  parameter int SW = SEL_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] src_tick,
  input  logic [SW-1:0] sel,
  input  logic          run,
  input  logic          adv,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  output logic          tick,
  output logic          level
);
  phase_t        phase;
  logic [CW-1:0] cnt, act_hi, act_lo;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NS; i++)
      if (sel == SW'(i)) tick = src_tick[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_HIGH;
      cnt    <= '0;
      act_hi <= '0;
      act_lo <= '0;
    end else if (!run) begin
      phase  <= PH_HIGH;
      cnt    <= '0;
      act_hi <= hi_cnt;
      act_lo <= lo_cnt;
    end else if (adv && tick) begin
      if (phase == PH_HIGH) begin
        if (cnt == act_hi) begin
          cnt   <= '0;
          phase <= PH_LOW;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == act_lo) begin
          cnt    <= '0;
          phase  <= PH_HIGH;
          act_hi <= hi_cnt;
          act_lo <= lo_cnt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign level = (phase == PH_HIGH);
endmodule

// File: rtl/tick_pwm_ctrl.sv
module tick_pwm_ctrl
  import pwmc_pkg::*;
#(
  parameter int N  = NCH,
  parameter int NS = NSRC,
  parameter int SW = SEL_W,
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NS-1:0] src_tick,
  output logic [N-2:0]  pwm_out,
  output logic          int_out
);
  localparam int NEXT = N - 1;

  logic [N-1:0][SW-1:0] sel_v;
  logic [N-1:0][CW-1:0] hi_v, lo_v;
  logic [N-1:0] byp_v, oe_v, tm_v, run_v, adv_v;
  logic [N-1:0] tick_v, level_v, out_q;

  pwmc_regs #(.N(N), .SW(SW), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sel_v(sel_v), .byp_v(byp_v), .oe_v(oe_v), .tm_v(tm_v),
    .run_v(run_v), .adv_v(adv_v), .hi_v(hi_v), .lo_v(lo_v)
  );

  for (genvar c = 0; c < N; c++) begin : g_ch
    pwmc_chan #(.NS(NS), .SW(SW), .CW(CW)) u_chan (
      .clk(clk), .rst(rst), .src_tick(src_tick), .sel(sel_v[c]),
      .run(run_v[c]), .adv(adv_v[c]), .hi_cnt(hi_v[c]), .lo_cnt(lo_v[c]),
      .tick(tick_v[c]), .level(level_v[c])
    );

    always_ff @(posedge clk) begin
      if (rst) out_q[c] <= 1'b0;
      else     out_q[c] <= oe_v[c] & tm_v[c] & (byp_v[c] ? tick_v[c] : level_v[c]);
    end
  end

  assign pwm_out = out_q[NEXT-1:0];
  assign int_out = out_q[N-1];
endmodule

// File: rtl/pwmc_chk.sv
module pwmc_chk
  import pwmc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [NCH-2:0]   pwm_out,
  input logic             int_out,
  input logic [NCH-1:0]   oe,
  input logic [NCH-1:0]   tm,
  input logic [NCH-1:0]   run,
  input logic [NCH-1:0]   adv,
  input logic [NCH-1:0]   level,
  input logic [SEL_W-1:0] sel0
);
  localparam logic [ADDR_W-1:0] TBL_END = A_TBL + ADDR_W'(8 * NCH);
  logic mapped;
  assign mapped = (addr == A_SEL) || (addr == A_OUT) || (addr == A_RUN) ||
                  (addr == A_ADV) ||
                  ((addr >= A_TBL) && (addr < TBL_END) && (addr[1:0] == 2'b00));

  a_r1_outputs_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwm_out == '0 && !int_out));

  a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> rdata == '0);

  a_r4_run_clear_holds_high: assert property (@(posedge clk) disable iff (rst)
    !run[0] |=> level[0]);

  a_r5_adv_clear_freezes: assert property (@(posedge clk) disable iff (rst)
    (run[0] && !adv[0]) |=> $stable(level[0]));

  a_r6_ch0_gated_low: assert property (@(posedge clk) disable iff (rst)
    !(oe[0] && tm[0]) |=> !pwm_out[0]);

  a_r6_ch6_gated_low: assert property (@(posedge clk) disable iff (rst)
    !(oe[NCH-1] && tm[NCH-1]) |=> !int_out);

  a_r9_sel_locked: assert property (@(posedge clk) disable iff (rst)
    run[0] |=> $stable(sel0));
endmodule

bind tick_pwm_ctrl pwmc_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rdata(rdata), .pwm_out(pwm_out),
  .int_out(int_out), .oe(oe_v), .tm(tm_v), .run(run_v), .adv(adv_v),
  .level(level_v), .sel0(sel_v[0])
);

// File: tb/tick_pwm_ctrl_tb.sv
`timescale 1ns/1ps
module tick_pwm_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  src_tick = '0;
  logic [5:0]  pwm_out;
  logic        int_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  tick_pwm_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_tick(src_tick), .pwm_out(pwm_out), .int_out(int_out)
  );

  always #4 clk = ~clk;

  function automatic int src_period(input int s);
    case (s)
      0: return 1;
      1: return 3;
      2: return 2;
      3: return 4;
      default: return 5;
    endcase
  endfunction

  initial begin
    int t;
    t = 0;
    forever begin
      @(posedge clk);
      #1;
      for (int s = 0; s < 5; s++) src_tick[s] = ((t % src_period(s)) == 0);
      t++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic ch_out(input int c);
    return (c < 6) ? pwm_out[c] : int_out;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h80;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
    addr = 8'h80;
  endtask

  task automatic wait_level(input int c, input logic v);
    int g;
    g = 0;
    while (ch_out(c) !== v && g < 4000) begin @(negedge clk); g++; end
  endtask

  task automatic run_len(input int c, input logic v, output int n);
    int g;
    n = 0; g = 0;
    while (ch_out(c) === v && g < 4000) begin n++; @(negedge clk); g++; end
  endtask

  task automatic measure(input int c, output int hi, output int lo);
    @(negedge clk);
    wait_level(c, 1'b0);
    wait_level(c, 1'b1);
    run_len(c, 1'b1, hi);
    run_len(c, 1'b0, lo);
  endtask

  initial begin
    logic [31:0] d;
    int hi, lo, ones, changes;
    logic v;
    logic [31:0] selw;

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    addr = 8'h80;

    // R1 reset state
    @(negedge clk);
    check("R1 pwm_out", pwm_out, 0);
    check("R1 int_out", int_out, 0);
    rd(8'h00, d); check("R1 select", d, 0);
    rd(8'h04, d); check("R1 output ctl", d, 0);
    rd(8'h08, d); check("R1 run gate", d, 0);
    rd(8'h44, d); check("R1 low count ch6", d, 0);

    // R2 readback and unmapped addresses
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 select", d, 32'hFFFF_FFFF);
    wr(8'h04, 32'hA5A5_3FFF); rd(8'h04, d); check("R2 output ctl", d, 32'hA5A5_3FFF);
    wr(8'h0C, 32'h1234_5678); rd(8'h0C, d); check("R2 advance gate", d, 32'h1234_5678);
    wr(8'h28, 32'h1234_ABCD); rd(8'h28, d); check("R2 high count ch3", d, 32'h1234_ABCD);
    wr(8'h44, 32'hFFFF_5678); rd(8'h44, d); check("R2 low count ch6", d, 32'hFFFF_5678);
    wr(8'h48, 32'hDEAD_BEEF); rd(8'h48, d); check("R2 unmapped 0x48", d, 0);
    rd(8'h11, d); check("R2 misaligned 0x11", d, 0);
    rd(8'h80, d); check("R2 unmapped 0x80", d, 0);
    rd(8'h28, d); check("R2 table unaffected", d, 32'h1234_ABCD);
    wr(8'h00, 0); wr(8'h0C, 0); wr(8'h44, 0); wr(8'h28, 0);
    wr(8'h04, 32'h0000_3FFF);

    // R3 sweep of small counts on channel 0, source 0 (tick every cycle)
    for (int w = 0; w < 4; w++) begin
      for (int h = 0; h < 4; h++) begin
        wr(8'h08, 0);
        wr(8'h10, w); wr(8'h14, h);
        wr(8'h08, 1); wr(8'h0C, 1);
        measure(0, hi, lo);
        check($sformatf("R3 high w=%0d h=%0d", w, h), hi, w + 1);
        check($sformatf("R3 low w=%0d h=%0d", w, h), lo, h + 1);
      end
    end

    // R8 / R11: all channels concurrently, distinct sources and counts
    wr(8'h08, 0); wr(8'h0C, 0);
    selw = 0;
    for (int c = 0; c < 7; c++) selw |= (32'(c % 5) << (3 * c));
    wr(8'h00, selw);
    for (int c = 0; c < 7; c++) begin
      wr(8'(8'h10 + 8 * c), c);
      wr(8'(8'h14 + 8 * c), 6 - c);
    end
    wr(8'h08, 32'h7F); wr(8'h0C, 32'h7F);
    for (int c = 0; c < 7; c++) begin
      measure(c, hi, lo);
      check($sformatf("R11 R8 high ch%0d", c), hi, src_period(c % 5) * (c + 1));
      check($sformatf("R11 R8 low ch%0d", c), lo, src_period(c % 5) * (7 - c));
    end

    // R8: source index 5 never advances, stays in high phase
    wr(8'h08, 0); wr(8'h0C, 0);
    wr(8'h10, 0); wr(8'h14, 0);
    wr(8'h00, 32'h5);
    wr(8'h08, 1); wr(8'h0C, 1);
    repeat (5) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 30; i++) begin ones += pwm_out[0]; @(negedge clk); end
    check("R8 idx5 frozen high", ones, 30);

    // R9: source field locked while run gate set
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R9 field kept", d[2:0], 5);
    wr(8'h08, 0);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R9 field written when unlocked", d[2:0], 0);

    // R4: clearing run gate returns to high phase
    wr(8'h10, 1); wr(8'h14, 40);
    wr(8'h08, 1); wr(8'h0C, 1);
    @(negedge clk);
    wait_level(0, 1'b0);
    wr(8'h08, 0);
    repeat (3) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 20; i++) begin ones += pwm_out[0]; @(negedge clk); end
    check("R4 held high", ones, 20);

    // R5: advance gate clear freezes the waveform
    wr(8'h10, 30); wr(8'h14, 30);
    wr(8'h08, 1); wr(8'h0C, 1);
    repeat (45) @(negedge clk);
    wr(8'h0C, 0);
    repeat (3) @(negedge clk);
    v = pwm_out[0];
    changes = 0;
    for (int i = 0; i < 80; i++) begin
      if (pwm_out[0] !== v) changes++;
      @(negedge clk);
    end
    check("R5 frozen", changes, 0);
    wr(8'h0C, 1);

    // R6: both output bits needed
    wr(8'h04, 32'h0000_3F80);
    repeat (3) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 80; i++) begin ones += pwm_out[0]; @(negedge clk); end
    check("R6 transfer-mode only low", ones, 0);
    wr(8'h04, 32'h0000_007F);
    repeat (3) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 80; i++) begin ones += pwm_out[0]; @(negedge clk); end
    check("R6 enable only low", ones, 0);
    wr(8'h04, 32'h0000_3FFF);
    repeat (3) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 80; i++) begin ones += pwm_out[0]; @(negedge clk); end
    check("R6 both set active", ones > 0, 1);

    // R7: bypass follows the selected tick
    wr(8'h08, 0);
    wr(8'h10, 5); wr(8'h14, 5);
    wr(8'h00, 32'h1 | (32'h1 << 21));
    repeat (3) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 30; i++) begin ones += pwm_out[0]; @(negedge clk); end
    check("R7 bypass src1 pulses", ones, 10);
    wr(8'h00, 32'h0 | (32'h1 << 21));
    repeat (3) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 30; i++) begin ones += pwm_out[0]; @(negedge clk); end
    check("R7 bypass src0 constant", ones, 30);
    wr(8'h00, 32'h0);

    // R10: count update takes effect at next period boundary
    wr(8'h08, 0);
    wr(8'h10, 9); wr(8'h14, 9);
    wr(8'h08, 1); wr(8'h0C, 1);
    @(negedge clk);
    wait_level(0, 1'b0);
    wait_level(0, 1'b1);
    wr(8'h10, 2); wr(8'h14, 3);
    wait_level(0, 1'b0);
    run_len(0, 1'b0, lo);
    check("R10 old low kept", lo, 10);
    run_len(0, 1'b1, hi);
    check("R10 new high", hi, 3);
    run_len(0, 1'b0, lo);
    check("R10 new low", lo, 4);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule